// File: doc/BRIEF.md
# Conditional Select Unit

This block picks a result for a conditional-select instruction. It tests a 4-bit condition code against the N, Z, C and V flags. When the condition holds, the result is the first operand. When it fails, the result is a second operand that has gone through one of four transforms: pass-through, increment, bitwise invert or two's-complement negate. Condition evaluation and the operand transform both run in the same combinational path, ahead of one output register.

Common shorthand forms need no extra hardware. They reach the block as ordinary requests with the zero value on both operands and the condition's low bit flipped. Set-on-condition gives 1 or 0. Set-mask gives all ones or 0. A valid strobe travels with each request. The registered result and its valid flag appear one cycle later.

Top module: `csel_unit`

## Requirements
- R1: With `op` = 0 (plain select), `result` is `opa` when the condition holds and `opb` when it fails.
- R2: With `op` = 1 (select-increment), `result` is `opb + 1` when the condition fails, wrapping modulo 2^WIDTH (all ones gives 0).
- R3: With `op` = 2 (select-invert), `result` is the bitwise complement of `opb` when the condition fails.
- R4: With `op` = 3 (select-negate), `result` is `0 - opb` when the condition fails, so a zero `opb` gives 0.
- R5: `flags` bits are N=3, Z=2, C=1, V=0. Codes 0..13 test, in order: Z set, Z clear, C set, C clear, N set, N clear, V set, V clear, C set with Z clear, its inverse, N equal to V, N unequal to V, Z clear with N equal to V, and its inverse.
- R6: Codes 14 and 15 always hold, so `result` is `opa` for every `op` and flag value.
- R7: Select-increment with both operands 0 and the condition's low bit flipped gives 1 when the original condition (codes 0..13) holds and 0 otherwise.
- R8: Select-invert with both operands 0 and the condition's low bit flipped gives all ones when the original condition (codes 0..13) holds and 0 otherwise.
- R9: `out_valid` in a cycle equals `in_valid` of the previous cycle, and `result` then carries that request's answer.
- R10: While `in_valid` is low, `result` keeps its last value.
- R11: In and just after synchronous reset, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Transform: 0 select, 1 increment, 2 invert, 3 negate |
| opa | input | WIDTH | Operand chosen when the condition holds |
| opb | input | WIDTH | Operand transformed when the condition fails |
| cond | input | 4 | Condition code |
| flags | input | 4 | N, Z, C, V flags, bit 3 down to bit 0 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | WIDTH | Registered result |

## Verification
The two functions that can fall in the same cycle are the condition decision and the transform boundary cases. One check combines a failing condition with an all-ones increment (which wraps) or with negating zero. A second case is a new request arriving in the cycle the previous result is presented. The bench issues back-to-back requests whose conditions differ and checks each presented result against the model. It also issues wrap and zero-negate requests under conditions that are computed to fail.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [1:0] {
    CS_SEL = 2'd0,
    CS_INC = 2'd1,
    CS_INV = 2'd2,
    CS_NEG = 2'd3
  } csel_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  // base test selected by cond[3:1]; cond[0] inverts it (except for 3'b111)
  localparam logic [2:0] BASE_ALWAYS = 3'b111;
endpackage

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
  import csel_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       taken
);
  logic fn, fz, fc, fv;
  logic base;

  assign fn = flags[FLAG_N];
  assign fz = flags[FLAG_Z];
  assign fc = flags[FLAG_C];
  assign fv = flags[FLAG_V];

  always_comb begin
    unique case (cond[3:1])
      3'd0:    base = fz;
      3'd1:    base = fc;
      3'd2:    base = fn;
      3'd3:    base = fv;
      3'd4:    base = fc & ~fz;
      3'd5:    base = (fn == fv);
      3'd6:    base = ~fz & (fn == fv);
      default: base = 1'b1;
    endcase
  end

  assign taken = (cond[0] && cond[3:1] != BASE_ALWAYS) ? ~base : base;
endmodule

// File: rtl/csel_xform.sv
module csel_xform
  import csel_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] alt
);
  csel_op_e op_e;
  assign op_e = csel_op_e'(op);

  always_comb begin
    unique case (op_e)
      CS_SEL:  alt = src;
      CS_INC:  alt = src + WIDTH'(1);
      CS_INV:  alt = ~src;
      default: alt = WIDTH'(0) - src;
    endcase
  end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       cond,
  input  logic [3:0]       flags,
  output logic             out_valid,
  output logic [WIDTH-1:0] result
);
  logic             taken;
  logic [WIDTH-1:0] alt;
  logic [WIDTH-1:0] pick;

  csel_cond_eval u_cond (
    .cond  (cond),
    .flags (flags),
    .taken (taken)
  );

  csel_xform #(.WIDTH(WIDTH)) u_xform (
    .op  (op),
    .src (opb),
    .alt (alt)
  );

  assign pick = taken ? opa : alt;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= pick;
    end
  end
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       op,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [3:0]       cond,
  input logic             taken,
  input logic             out_valid,
  input logic [WIDTH-1:0] result
);
  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R1
  taken_pick_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && taken |=> result == $past(opa));
  // R1
  sel_fail_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !taken && op == 2'd0 |=> result == $past(opb));
  // R2
  inc_fail_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !taken && op == 2'd1 |=> result == $past(opb) + WIDTH'(1));
  // R3
  inv_fail_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !taken && op == 2'd2 |=> result == ~$past(opb));
  // R4
  neg_fail_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !taken && op == 2'd3 |=> (result + $past(opb)) == '0);
  // R6
  always_true_chk: assert property (@(posedge clk) disable iff (rst)
    cond[3:1] == 3'b111 |-> taken);
endmodule

bind csel_unit csel_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .opa       (opa),
  .opb       (opb),
  .cond      (cond),
  .taken     (taken),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/test_csel_unit.sv
module test_csel_unit;
  localparam int W = 64;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   op = '0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [3:0]   cond = '0;
  logic [3:0]   flags = '0;
  logic         out_valid;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  csel_unit #(.WIDTH(W)) i_csel_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa),
    .opb(opb), .cond(cond), .flags(flags), .out_valid(out_valid),
    .result(result)
  );

  function automatic logic exp_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !(cy && !z);
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return !(!z && (n == v));
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_res(input logic [1:0] o, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic [3:0] c,
                                           input logic [3:0] f);
    if (exp_cond(c, f)) return a;
    case (o)
      2'd0: return b;
      2'd1: return b + 1;
      2'd2: return ~b;
      default: return ~b + 1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] c, input logic [3:0] f);
    op = o; opa = a; opb = b; cond = c; flags = f; in_valid = 1'b1;
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic apply(input string tag, input logic [1:0] o, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [3:0] c, input logic [3:0] f,
                       input logic [W-1:0] exp);
    drive(o, a, b, c, f);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, W'(out_valid), W'(1));
    check(tag, result, exp);
  endtask

  task automatic t_reset();
    check("R11 out_valid", W'(out_valid), W'(0));
    check("R11 result", result, '0);
  endtask

  task automatic t_select();
    apply("R1 true", 2'd0, 64'h1111, 64'h2222, 4'd0, 4'b0100, 64'h1111);
    apply("R1 false", 2'd0, 64'h1111, 64'h2222, 4'd0, 4'b0000, 64'h2222);
  endtask

  task automatic t_incr();
    apply("R2 wrap", 2'd1, 64'h5, ONES, 4'd1, 4'b0100, '0);
    apply("R2 plain", 2'd1, 64'h5, 64'h41, 4'd2, 4'b0000, 64'h42);
    apply("R2 true", 2'd1, 64'h5, 64'h41, 4'd2, 4'b0010, 64'h5);
  endtask

  task automatic t_invert();
    apply("R3 false", 2'd2, 64'h7, 64'h00ff_0000_1234_5678, 4'd4, 4'b0000,
          64'hff00_ffff_edcb_a987);
    apply("R3 true", 2'd2, 64'h7, 64'h1, 4'd4, 4'b1000, 64'h7);
  endtask

  task automatic t_negate();
    apply("R4 zero", 2'd3, 64'h9, '0, 4'd6, 4'b0000, '0);
    apply("R4 five", 2'd3, 64'h9, 64'd5, 4'd6, 4'b0000, ~64'd5 + 1);
    apply("R4 min", 2'd3, 64'h9, 64'h8000_0000_0000_0000, 4'd7, 4'b0001,
          64'h8000_0000_0000_0000);
  endtask

  task automatic t_conds();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply(c >= 14 ? "R6 always" : "R5 cond", 2'(c % 4), 64'hA5, 64'h3C,
              4'(c), 4'(f), exp_res(2'(c % 4), 64'hA5, 64'h3C, 4'(c), 4'(f)));
      end
    end
  endtask

  task automatic t_alias();
    for (int c = 0; c < 14; c++) begin
      for (int f = 0; f < 16; f += 5) begin
        apply("R7 set", 2'd1, '0, '0, 4'(c) ^ 4'd1, 4'(f),
              exp_cond(4'(c), 4'(f)) ? 64'd1 : 64'd0);
        apply("R8 mask", 2'd2, '0, '0, 4'(c) ^ 4'd1, 4'(f),
              exp_cond(4'(c), 4'(f)) ? ONES : 64'd0);
      end
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] kept;
    apply("R10 prime", 2'd0, 64'hBEEF, 64'h0, 4'd14, 4'b0000, 64'hBEEF);
    kept = result;
    op = 2'd3; opa = 64'h1; opb = 64'h2; cond = 4'd1; flags = 4'b0100;
    @(negedge clk);
    @(negedge clk);
    check("R10 held", result, kept);
    check("R10 idle valid", W'(out_valid), W'(0));
  endtask

  task automatic t_b2b();
    drive(2'd1, 64'h10, 64'h20, 4'd0, 4'b0100);
    @(negedge clk);
    check("R9 first", result, 64'h10);
    check("R9 first valid", W'(out_valid), W'(1));
    drive(2'd1, 64'h10, ONES, 4'd0, 4'b0000);
    @(negedge clk);
    check("R9 second", result, '0);
    check("R9 second valid", W'(out_valid), W'(1));
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 drop valid", W'(out_valid), W'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_select();
    t_incr();
    t_invert();
    t_negate();
    t_conds();
    t_alias();
    t_hold();
    t_b2b();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule